// File: doc/BRIEF.md
# Pin Interrupt Redirection Entries with Remote IRR

This block holds a small table of pin-driven redirection entries. Each entry watches one interrupt pin and is programmed with an 8-bit vector, a trigger mode (edge or level) and a mask bit. When an entry sees its interrupt condition, it raises a request. A shared output stage carries one message at a time, made of the vector and the entry index, over a valid/ready handshake. When several entries request in the same cycle, the lowest index goes first.

The two trigger modes track completion differently. An edge-mode entry records a rising edge in a delivery-status bit. It ignores all further edges until the message for that edge is accepted. The edge only counts if the pin is still high when the entry wins the output stage. A level-mode entry sets its remote IRR flag once its message is accepted, and it stays silent until an end-of-interrupt (EOI) message arrives carrying the same vector. If the pin is still high when the flag clears, the entry sends a new message.

Top module: `irq_route_table`

## Requirements
- R1: After reset, `msg_valid_o` is 0 and every entry is masked, in edge mode, with vector 0. A pin that rises before any configuration produces no message.
- R2: An unmasked edge-mode entry (`cfg_level_i`=0) whose pin is first sampled high at clock edge k, and is still high at edge k+1, presents its message at edge k+1. The message is `msg_src_o` = entry index and `msg_vec_o` = programmed vector, and it is presented exactly once.
- R3: While an edge-mode entry has delivery pending, further pin edges are ignored. Once its message is accepted, the entry sends nothing more until the pin falls and rises again.
- R4: If an edge-mode pin falls before its entry has won the output stage, the edge is dropped and no message is sent.
- R5: An unmasked level-mode entry (`cfg_level_i`=1) with its pin high presents a message at the first clock edge that samples the pin high. Acceptance sets its remote IRR flag, and no further message follows while the pin stays high.
- R6: An EOI (`eoi_valid_i`=1 for one cycle) whose `eoi_vector_i` equals the vector of one or more level-mode entries clears remote IRR in all of them. Each of those entries whose pin is still high then sends one new message.
- R7: An EOI whose vector matches no level-mode entry has no effect, including when it matches an edge-mode entry's vector.
- R8: A masked entry sends no message. A rising edge seen while an edge-mode entry is masked is not remembered after unmasking. A level-mode entry that is unmasked with its pin high sends a message.
- R9: Among entries requesting at the same time, the message of the lowest index is presented first.
- R10: A presented message holds its index and vector unchanged until `msg_ready_i` is 1. `msg_valid_o` is 0 in the cycle after each acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_ENTRIES | Interrupt pins, one per entry |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Entry selected by the configuration write |
| cfg_vector_i | input | 8 | Vector to program |
| cfg_level_i | input | 1 | Trigger mode: 1 level, 0 edge |
| cfg_mask_i | input | 1 | Mask: 1 blocks messages |
| msg_valid_o | output | 1 | Message present |
| msg_ready_i | input | 1 | Receiver accepts the message |
| msg_src_o | output | IDX_W | Index of the entry that sent the message |
| msg_vec_o | output | 8 | Vector carried by the message |
| eoi_valid_i | input | 1 | EOI message strobe |
| eoi_vector_i | input | 8 | Vector carried by the EOI |

## Verification
The hardest case to reach is an edge-mode entry whose pin toggles while its own message is held at the output. Those toggles must not re-arm the entry or cancel the message in flight. The stimulus holds `msg_ready_i` low, wiggles the pin across several cycles, and then releases ready with the pin left high. The scoreboard must then see exactly one message, and a second one only after a fresh low-to-high transition. A second hard case is clearing remote IRR on two level-mode entries that share a vector. The stimulus arms both, then sends a single matching EOI and expects both to fire again in index order.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    parameter int VEC_W = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        trig_e            trig;
        logic             mask;
    } entry_cfg_t;

    localparam entry_cfg_t CFG_RESET = '{vector: '0, trig: TRIG_EDGE, mask: 1'b1};

endpackage

// File: rtl/irq_entry.sv
module irq_entry
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic             cfg_we_i,
    input  entry_cfg_t       cfg_i,
    input  logic             launched_i,
    input  logic             accept_i,
    input  logic             eoi_valid_i,
    input  logic [VEC_W-1:0] eoi_vector_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             level_o,
    output logic             rirr_o
);
    entry_cfg_t cfg_q;
    logic       pin_q;
    logic       pend_q;
    logic       rirr_q;
    logic       is_level;
    logic       rising;
    logic       eoi_hit;

    assign is_level = (cfg_q.trig == TRIG_LEVEL);
    assign rising   = pin_i & ~pin_q;
    assign eoi_hit  = eoi_valid_i & is_level & (eoi_vector_i == cfg_q.vector);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            pin_q  <= 1'b0;
            pend_q <= 1'b0;
            rirr_q <= 1'b0;
        end else begin
            if (cfg_we_i) cfg_q <= cfg_i;
            pin_q <= pin_i;

            // edge mode: delivery pending until the message is taken
            if (is_level || accept_i)
                pend_q <= 1'b0;
            else if (pend_q && !launched_i && !pin_i)
                pend_q <= 1'b0;
            else if (!pend_q && rising && !cfg_q.mask)
                pend_q <= 1'b1;

            // level mode: remote IRR between acceptance and matching EOI
            if (!is_level)
                rirr_q <= 1'b0;
            else if (accept_i)
                rirr_q <= 1'b1;
            else if (eoi_hit)
                rirr_q <= 1'b0;
        end
    end

    always_comb begin
        if (cfg_q.mask || launched_i)
            req_o = 1'b0;
        else if (is_level)
            req_o = pin_i & ~rirr_q;
        else
            req_o = pend_q & pin_i;
    end

    assign vector_o = cfg_q.vector;
    assign level_o  = is_level;
    assign rirr_o   = rirr_q;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N_ENTRIES = 4,
    parameter int IDX_W     = 2
) (
    input  logic [N_ENTRIES-1:0] req_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_msg_out.sv
module irq_msg_out
    import irq_route_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any_i,
    input  logic [IDX_W-1:0] src_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] src_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             accept_o
);
    assign accept_o = valid_o & ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            src_o   <= '0;
            vec_o   <= '0;
        end else if (accept_o) begin
            valid_o <= 1'b0;
        end else if (!valid_o && any_i) begin
            valid_o <= 1'b1;
            src_o   <= src_i;
            vec_o   <= vec_i;
        end
    end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_ENTRIES-1:0] pin_i,
    input  logic                 cfg_we_i,
    input  logic [IDX_W-1:0]     cfg_idx_i,
    input  logic [VEC_W-1:0]     cfg_vector_i,
    input  logic                 cfg_level_i,
    input  logic                 cfg_mask_i,
    output logic                 msg_valid_o,
    input  logic                 msg_ready_i,
    output logic [IDX_W-1:0]     msg_src_o,
    output logic [VEC_W-1:0]     msg_vec_o,
    input  logic                 eoi_valid_i,
    input  logic [VEC_W-1:0]     eoi_vector_i
);
    entry_cfg_t           cfg_word;
    logic [N_ENTRIES-1:0] req_vec;
    logic [N_ENTRIES-1:0] level_vec;
    logic [N_ENTRIES-1:0] rirr_vec;
    logic [N_ENTRIES-1:0] launched_vec;
    logic [N_ENTRIES-1:0] accept_vec;
    logic [VEC_W-1:0]     vec_arr [N_ENTRIES];
    logic                 pick_any;
    logic [IDX_W-1:0]     pick_idx;
    logic                 accept;

    assign cfg_word = '{vector: cfg_vector_i, trig: trig_e'(cfg_level_i), mask: cfg_mask_i};

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        assign launched_vec[g] = msg_valid_o & (msg_src_o == IDX_W'(g));
        assign accept_vec[g]   = accept & (msg_src_o == IDX_W'(g));

        irq_entry u_entry (
            .clk          (clk),
            .rst          (rst),
            .pin_i        (pin_i[g]),
            .cfg_we_i     (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
            .cfg_i        (cfg_word),
            .launched_i   (launched_vec[g]),
            .accept_i     (accept_vec[g]),
            .eoi_valid_i  (eoi_valid_i),
            .eoi_vector_i (eoi_vector_i),
            .req_o        (req_vec[g]),
            .vector_o     (vec_arr[g]),
            .level_o      (level_vec[g]),
            .rirr_o       (rirr_vec[g])
        );
    end

    irq_pick #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .req_i (req_vec),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    irq_msg_out #(.IDX_W(IDX_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .any_i    (pick_any),
        .src_i    (pick_idx),
        .vec_i    (vec_arr[pick_idx]),
        .ready_i  (msg_ready_i),
        .valid_o  (msg_valid_o),
        .src_o    (msg_src_o),
        .vec_o    (msg_vec_o),
        .accept_o (accept)
    );

endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker #(
    parameter int N_ENTRIES = 4,
    parameter int IDX_W     = 2,
    parameter int VEC_W     = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 valid,
    input logic                 ready,
    input logic [IDX_W-1:0]     src,
    input logic [VEC_W-1:0]     vec,
    input logic [N_ENTRIES-1:0] req_vec,
    input logic [N_ENTRIES-1:0] level_vec,
    input logic [N_ENTRIES-1:0] rirr_vec
);
    logic [N_ENTRIES-1:0] below_src;
    assign below_src = (N_ENTRIES'(1) << src) - N_ENTRIES'(1);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(src) && $stable(vec)));

    p_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> !valid);

    p_lowest_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> (($past(req_vec) & below_src) == '0));

    p_rirr_set_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && ready && level_vec[src]) |=> rirr_vec[$past(src)]);

endmodule

bind irq_route_table irq_route_checker #(
    .N_ENTRIES (N_ENTRIES),
    .IDX_W     (IDX_W),
    .VEC_W     (irq_route_pkg::VEC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid     (msg_valid_o),
    .ready     (msg_ready_i),
    .src       (msg_src_o),
    .vec       (msg_vec_o),
    .req_vec   (req_vec),
    .level_vec (level_vec),
    .rirr_vec  (rirr_vec)
);

// File: tb/test_irq_route_table.sv
module test_irq_route_table;
    localparam int N  = 4;
    localparam int IW = 2;

    typedef struct packed {
        logic [IW-1:0] src;
        logic [7:0]    vec;
    } msg_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pin = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [7:0]    cfg_vec = '0;
    logic          cfg_level = 1'b0;
    logic          cfg_mask = 1'b1;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [IW-1:0] msg_src;
    logic [7:0]    msg_vec;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vec = '0;

    int   n_chk = 0;
    int   n_err = 0;
    bit   run = 1'b0;
    bit   prev_acc = 1'b0;
    msg_t exp_q[$];

    always #2 clk = ~clk;

    irq_route_table i_irq_route_table (
        .clk          (clk),
        .rst          (rst),
        .pin_i        (pin),
        .cfg_we_i     (cfg_we),
        .cfg_idx_i    (cfg_idx),
        .cfg_vector_i (cfg_vec),
        .cfg_level_i  (cfg_level),
        .cfg_mask_i   (cfg_mask),
        .msg_valid_o  (msg_valid),
        .msg_ready_i  (msg_ready),
        .msg_src_o    (msg_src),
        .msg_vec_o    (msg_vec),
        .eoi_valid_i  (eoi_valid),
        .eoi_vector_i (eoi_vec)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares every accepted message with the queue
    always @(negedge clk) begin
        if (run) begin
            if (prev_acc) chk(!msg_valid, "R10 gap after accept", 32'(msg_valid), 0);
            if (msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected message", {msg_src, msg_vec}, 0);
                end else begin
                    msg_t e;
                    e = exp_q.pop_front();
                    chk(msg_src == e.src && msg_vec == e.vec, "R9 message order/content",
                        {msg_src, msg_vec}, {e.src, e.vec});
                end
            end
            prev_acc = msg_valid && msg_ready;
        end
    end

    task automatic expect_msg(input int src, input logic [7:0] vec);
        msg_t m;
        m.src = IW'(src);
        m.vec = vec;
        exp_q.push_back(m);
    endtask

    task automatic settle(input int n, input string tag);
        repeat (n) @(negedge clk);
        #1;
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic cfg(input int idx, input logic [7:0] vec, input bit level, input bit mask);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_vec = vec; cfg_level = level; cfg_mask = mask;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] vec);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vec = vec;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [IW-1:0] held_src;
        logic [7:0]    held_vec;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run = 1'b1;
        // R1: reset state, entries masked by default
        chk(!msg_valid, "R1 valid after reset", 32'(msg_valid), 0);
        @(negedge clk); pin[0] = 1'b1;
        settle(6, "R1 default masked entry silent");
        pin[0] = 1'b0;
        settle(2, "R1 still silent");

        // R2: edge entry timing and single message
        cfg(0, 8'h21, 1'b0, 1'b0);
        @(negedge clk); pin[0] = 1'b1; expect_msg(0, 8'h21);
        @(negedge clk);
        chk(!msg_valid, "R2 not before second edge", 32'(msg_valid), 0);
        @(negedge clk);
        chk(msg_valid && msg_src == 0 && msg_vec == 8'h21, "R2 message at second edge",
            {msg_valid, msg_src, msg_vec}, {1'b1, 2'd0, 8'h21});
        settle(8, "R2 exactly one message");
        pin[0] = 1'b0;
        settle(3, "R2 quiet after fall");

        // R3 and R10: edges while delivery pending are ignored, message held
        msg_ready = 1'b0;
        @(negedge clk); pin[0] = 1'b1; expect_msg(0, 8'h21);
        repeat (3) @(negedge clk);
        held_src = msg_src; held_vec = msg_vec;
        chk(msg_valid, "R10 message presented while not ready", 32'(msg_valid), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); pin[0] = ~pin[0];
        end
        @(negedge clk);
        chk(msg_valid && msg_src == held_src && msg_vec == held_vec, "R10 held stable",
            {msg_valid, msg_src, msg_vec}, {1'b1, held_src, held_vec});
        msg_ready = 1'b1;
        settle(8, "R3 toggles during pending ignored");
        @(negedge clk); pin[0] = 1'b0;
        @(negedge clk); pin[0] = 1'b1; expect_msg(0, 8'h21);
        settle(8, "R3 new edge after accept");
        pin[0] = 1'b0;

        // R4: pulse too short to reach the output stage
        cfg(1, 8'h32, 1'b0, 1'b0);
        @(negedge clk); pin[1] = 1'b1;
        @(negedge clk); pin[1] = 1'b0;
        settle(8, "R4 dropped edge");

        // R5, R9: two level entries sharing a vector
        cfg(2, 8'h45, 1'b1, 1'b0);
        cfg(3, 8'h45, 1'b1, 1'b0);
        @(negedge clk); pin[2] = 1'b1; pin[3] = 1'b1;
        expect_msg(2, 8'h45); expect_msg(3, 8'h45);
        settle(12, "R5 one message each while remote IRR set");

        // R7: unmatched EOIs
        eoi(8'h99);
        settle(8, "R7 unmatched EOI no effect");
        eoi(8'h21);
        settle(8, "R7 edge-entry vector EOI no effect");

        // R6: one EOI clears both, pins still high
        expect_msg(2, 8'h45); expect_msg(3, 8'h45);
        eoi(8'h45);
        settle(10, "R6 re-fire after EOI");
        @(negedge clk); pin[2] = 1'b0; pin[3] = 1'b0;
        eoi(8'h45);
        settle(6, "R6 no message when pin low");

        // R8: masked edge and level entries
        cfg(1, 8'h32, 1'b0, 1'b1);
        @(negedge clk); pin[1] = 1'b1;
        settle(6, "R8 masked edge silent");
        cfg(1, 8'h32, 1'b0, 1'b0);
        settle(6, "R8 masked edge not remembered");
        pin[1] = 1'b0;
        cfg(2, 8'h45, 1'b1, 1'b1);
        @(negedge clk); pin[2] = 1'b1;
        settle(6, "R8 masked level silent");
        expect_msg(2, 8'h45);
        cfg(2, 8'h45, 1'b1, 1'b0);
        settle(8, "R8 level fires on unmask");
        @(negedge clk); pin[2] = 1'b0;
        eoi(8'h45);

        // R9: two edge entries together
        @(negedge clk); pin[1] = 1'b1; pin[0] = 1'b1;
        expect_msg(0, 8'h21); expect_msg(1, 8'h32);
        settle(10, "R9 lowest index first");
        pin[0] = 1'b0; pin[1] = 1'b0;
        settle(4, "R9 quiet at end");

        run = 1'b0;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule